// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block is one doorbell channel of a multi-processor chip. Other processors ring it, and each ring names the master that sent it. Software on the owning processor chooses which masters may ring the channel through a per-master enable mask. Every ring is recorded by master ID in a raw register, whether or not it is enabled. A ring from an enabled master is also latched into a pending register. While any pending bit is set, the interrupt output stays high.

There are two ways to ring the channel. The local register port can write the trigger word and supply a master ID with the write. A separate remote ring port carries a trigger write from another processor together with its master ID. Both paths can ring in the same cycle. Software reads the enable, raw and pending registers through a combinational read port. It clears raw and pending bits by writing ones. When a ring and a clear hit the same bit in one cycle, the ring is kept.

Top module: `db_unit`

## Requirements
- R1: After reset, the enable, raw and pending registers read as zero, and `irq` is low.
- R2: Writing exactly 32'h1 to the trigger word (offset 0x0) rings the channel, either from the local port with master `wr_src` or on the remote port with master `ring_src`. A ring sets bit `m` of the raw word (offset 0x8) at the next clock edge. Any other written value has no effect. The trigger word always reads as 0.
- R3: A ring from master `m` sets pending bit `m` (offset 0xC) only when enable bit `m` was already set before the clock edge on which the ring arrives. An enable write in the same cycle does not qualify that ring.
- R4: A write to the enable word (offset 0x4) replaces the whole mask. Bits at positions NUM_MASTERS and above read as zero.
- R5: Writing to the raw word clears each raw bit whose written bit is 1. Raw bits written with 0 keep their value, and the pending register is not affected.
- R6: Writing to the pending word clears each pending bit whose written bit is 1. Pending bits written with 0 keep their value, and the raw register is not affected.
- R7: When a ring and a clear of the same raw or pending bit fall in the same cycle, the bit ends up set.
- R8: `irq` is high exactly while at least one pending bit is set, with no added register stage.
- R9: A ring whose master ID is NUM_MASTERS or greater changes no register.
- R10: A local ring and a remote ring in the same cycle are both recorded.
- R11: A write whose address has bit 1 or bit 0 set is ignored. A read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Local register write strobe |
| wr_addr | input | 4 | Local write byte offset |
| wr_data | input | 32 | Local write data |
| wr_src | input | MID_W | Master ID sent with a local trigger write |
| ring_wr | input | 1 | Remote trigger write strobe |
| ring_data | input | 32 | Remote trigger write data |
| ring_src | input | MID_W | Master ID of the remote ring |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | High while any pending bit is set |

## Verification
The bench builds the unit with NUM_MASTERS = 6. The master-ID field is then 3 bits wide, so IDs 6 and 7 can be driven but name no master. This setting reaches the out-of-range ring case and the zero-filled upper mask bits, which cannot occur at the default width. The bench also drives the remote and local ports in the same cycle, which is the only way to produce a ring-against-clear conflict or an enable write racing a ring.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int unsigned DB_DATA_W = 32;
  localparam int unsigned DB_AW     = 4;

  typedef enum logic [1:0] {
    SLOT_TRIG = 2'd0,
    SLOT_MASK = 2'd1,
    SLOT_RAW  = 2'd2,
    SLOT_PEND = 2'd3
  } slot_e;

  // word-aligned offsets only; bits [1:0] must be zero
  function automatic logic addr_aligned(input logic [DB_AW-1:0] a);
    return a[1:0] == 2'b00;
  endfunction

  function automatic slot_e slot_of(input logic [DB_AW-1:0] a);
    return slot_e'(a[3:2]);
  endfunction

  // a trigger write rings only with the exact value one
  function automatic logic is_ring_word(input logic [DB_DATA_W-1:0] d);
    return d == DB_DATA_W'(1);
  endfunction
endpackage

// File: rtl/db_ring_decode.sv
module db_ring_decode #(
  parameter int unsigned NUM_MASTERS = 32,
  parameter int unsigned MID_W       = 5
) (
  input  logic                   loc_hit,
  input  logic [MID_W-1:0]       loc_src,
  input  logic                   rem_hit,
  input  logic [MID_W-1:0]       rem_src,
  output logic [NUM_MASTERS-1:0] ring_vec
);
  // IDs at or above NUM_MASTERS match no lane and fall away here
  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_lane
    assign ring_vec[i] = (loc_hit && (loc_src == MID_W'(i))) ||
                         (rem_hit && (rem_src == MID_W'(i)));
  end
endmodule

// File: rtl/db_flag_bank.sv
module db_flag_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] q
);
  // set has priority over clear on every bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set_vec[i]) q[i] <= 1'b1;
      else if (clr_vec[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/db_unit.sv
module db_unit
  import db_pkg::*;
#(
  parameter  int unsigned NUM_MASTERS = 32,
  localparam int unsigned MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DB_AW-1:0]     wr_addr,
  input  logic [DB_DATA_W-1:0] wr_data,
  input  logic [MID_W-1:0]     wr_src,
  input  logic                 ring_wr,
  input  logic [DB_DATA_W-1:0] ring_data,
  input  logic [MID_W-1:0]     ring_src,
  input  logic [DB_AW-1:0]     rd_addr,
  output logic [DB_DATA_W-1:0] rd_data,
  output logic                 irq
);
  localparam int unsigned NM = NUM_MASTERS;

  // named internal events
  slot_e           wr_slot;
  slot_e           rd_slot;
  logic            wr_ok;
  logic            loc_hit;
  logic            rem_hit;
  logic            en_wr;
  logic [NM-1:0]   ring_vec;
  logic [NM-1:0]   pend_set;
  logic [NM-1:0]   raw_clr;
  logic [NM-1:0]   pend_clr;
  logic [NM-1:0]   en_q;
  logic [NM-1:0]   raw_q;
  logic [NM-1:0]   pend_q;

  assign wr_slot = slot_of(wr_addr);
  assign rd_slot = slot_of(rd_addr);
  assign wr_ok   = wr_en && addr_aligned(wr_addr);
  assign loc_hit = wr_ok && (wr_slot == SLOT_TRIG) && is_ring_word(wr_data);
  assign rem_hit = ring_wr && is_ring_word(ring_data);
  assign en_wr   = wr_ok && (wr_slot == SLOT_MASK);
  assign raw_clr  = (wr_ok && (wr_slot == SLOT_RAW))  ? wr_data[NM-1:0] : '0;
  assign pend_clr = (wr_ok && (wr_slot == SLOT_PEND)) ? wr_data[NM-1:0] : '0;

  db_ring_decode #(.NUM_MASTERS(NM), .MID_W(MID_W)) u_dec (
    .loc_hit (loc_hit),
    .loc_src (wr_src),
    .rem_hit (rem_hit),
    .rem_src (ring_src),
    .ring_vec(ring_vec)
  );

  // enable qualifies with the value held before this edge
  assign pend_set = ring_vec & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wr_data[NM-1:0];
  end

  db_flag_bank #(.WIDTH(NM)) u_raw (
    .clk(clk), .rst_n(rst_n), .set_vec(ring_vec), .clr_vec(raw_clr), .q(raw_q)
  );

  db_flag_bank #(.WIDTH(NM)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(pend_set), .clr_vec(pend_clr), .q(pend_q)
  );

  always_comb begin
    rd_data = '0;
    if (addr_aligned(rd_addr)) begin
      unique case (rd_slot)
        SLOT_MASK: rd_data = DB_DATA_W'(en_q);
        SLOT_RAW:  rd_data = DB_DATA_W'(raw_q);
        SLOT_PEND: rd_data = DB_DATA_W'(pend_q);
        default:   rd_data = '0;
      endcase
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/db_unit_chk.sv
module db_unit_chk #(
  parameter int unsigned NUM_MASTERS = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq,
  input logic [NUM_MASTERS-1:0] ring_vec,
  input logic [NUM_MASTERS-1:0] pend_set,
  input logic [NUM_MASTERS-1:0] raw_clr,
  input logic [NUM_MASTERS-1:0] pend_clr,
  input logic [NUM_MASTERS-1:0] en_q,
  input logic [NUM_MASTERS-1:0] raw_q,
  input logic [NUM_MASTERS-1:0] pend_q
);
  AST_RING_KEPT_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_q & $past(ring_vec)) == $past(ring_vec))); // R7

  AST_RAW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_q & $past(raw_clr & ~ring_vec)) == '0)); // R5

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & $past(pend_clr & ~pend_set)) == '0)); // R6

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0)); // R3

  AST_IRQ_FROM_RING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(irq)) |-> ($past(pend_set) != '0)); // R8
endmodule

bind db_unit db_unit_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ring_vec(ring_vec), .pend_set(pend_set),
  .raw_clr(raw_clr), .pend_clr(pend_clr), .en_q(en_q), .raw_q(raw_q), .pend_q(pend_q)
);

// File: tb/db_unit_bench.sv
module db_unit_bench;
  localparam int NM = 6;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [MW-1:0] wr_src = '0;
  logic          ring_wr = 1'b0;
  logic [31:0]   ring_data = '0;
  logic [MW-1:0] ring_src = '0;
  logic [3:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  db_unit #(.NUM_MASTERS(NM)) u_db_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_src(wr_src), .ring_wr(ring_wr), .ring_data(ring_data), .ring_src(ring_src),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference model
  bit [NM-1:0] m_en, m_raw, m_pend;

  always @(posedge clk) begin
    bit [NM-1:0] rv, rclr, pclr, en_old;
    if (!rst_n) begin
      m_en = '0; m_raw = '0; m_pend = '0;
    end else begin
      rv = '0; rclr = '0; pclr = '0; en_old = m_en;
      if (wr_en && wr_addr == 4'h0 && wr_data == 32'd1 && int'(wr_src) < NM) rv[wr_src] = 1'b1;
      if (ring_wr && ring_data == 32'd1 && int'(ring_src) < NM) rv[ring_src] = 1'b1;
      if (wr_en && wr_addr == 4'h8) rclr = wr_data[NM-1:0];
      if (wr_en && wr_addr == 4'hC) pclr = wr_data[NM-1:0];
      if (wr_en && wr_addr == 4'h4) m_en = wr_data[NM-1:0];
      m_raw  = (m_raw & ~rclr) | rv;
      m_pend = (m_pend & ~pclr) | (rv & en_old);
    end
  end

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'h4:    return 32'(m_en);
      4'h8:    return 32'(m_raw);
      4'hC:    return 32'(m_pend);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && mon_on) begin
      chk("R8 irq", 32'(irq), 32'(m_pend != '0));
      chk({cur_tag, " read"}, rd_data, model_read(rd_addr));
    end
  end

  task automatic cyc(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                     input logic [MW-1:0] ws, input logic re, input logic [31:0] rdat,
                     input logic [MW-1:0] rs);
    @(posedge clk); #1;
    wr_en = we; wr_addr = wa; wr_data = wd; wr_src = ws;
    ring_wr = re; ring_data = rdat; ring_src = rs;
    @(posedge clk); #1;
    wr_en = 1'b0; ring_wr = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    expect_reg("R1 enable", 4'h4, 32'h0);
    expect_reg("R1 raw", 4'h8, 32'h0);
    expect_reg("R1 pending", 4'hC, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 / R3 ring while disabled
    cur_tag = "R2";
    cyc(1, 4'h0, 32'h1, 3'd2, 0, 0, 0);
    expect_reg("R2 raw bit2", 4'h8, 32'h04);
    expect_reg("R3 no pending when disabled", 4'hC, 32'h0);
    expect_reg("R2 trigger reads zero", 4'h0, 32'h0);
    cyc(1, 4'h0, 32'h3, 3'd1, 1, 32'h2, 3'd0);
    expect_reg("R2 non-one value ignored", 4'h8, 32'h04);

    // R4 enable replace, upper bits zero
    cur_tag = "R4";
    cyc(1, 4'h4, 32'hFFFF_FFFF, 0, 0, 0, 0);
    expect_reg("R4 mask width", 4'h4, 32'h3F);
    cyc(1, 4'h4, 32'h0000_0025, 0, 0, 0, 0);
    expect_reg("R4 replace", 4'h4, 32'h25);

    // R3 / R8 enabled ring
    cur_tag = "R3";
    cyc(0, 0, 0, 0, 1, 32'h1, 3'd2);
    expect_reg("R3 pending bit2", 4'hC, 32'h04);
    chk("R8 irq high", 32'(irq), 32'h1);
    cyc(0, 0, 0, 0, 1, 32'h1, 3'd1);
    expect_reg("R3 disabled master1 not pending", 4'hC, 32'h04);
    expect_reg("R2 raw bits 1,2", 4'h8, 32'h06);

    // R5 raw W1C
    cur_tag = "R5";
    cyc(1, 4'h8, 32'h04, 0, 0, 0, 0);
    expect_reg("R5 raw cleared bit2", 4'h8, 32'h02);
    expect_reg("R5 pending untouched", 4'hC, 32'h04);

    // R6 pending W1C, R8 irq drop
    cur_tag = "R6";
    cyc(1, 4'hC, 32'h01, 0, 0, 0, 0);
    expect_reg("R6 zero bits keep", 4'hC, 32'h04);
    cyc(1, 4'hC, 32'h04, 0, 0, 0, 0);
    expect_reg("R6 pending cleared", 4'hC, 32'h0);
    expect_reg("R6 raw untouched", 4'h8, 32'h02);
    chk("R8 irq low", 32'(irq), 32'h0);

    // R9 out-of-range IDs
    cur_tag = "R9";
    cyc(1, 4'h0, 32'h1, 3'd7, 1, 32'h1, 3'd6);
    expect_reg("R9 raw unchanged", 4'h8, 32'h02);
    expect_reg("R9 pending unchanged", 4'hC, 32'h0);

    // R7 ring against clear
    cur_tag = "R7";
    cyc(0, 0, 0, 0, 1, 32'h1, 3'd0);
    cyc(1, 4'hC, 32'h01, 0, 1, 32'h1, 3'd0);
    expect_reg("R7 pending ring wins", 4'hC, 32'h01);
    cyc(1, 4'h8, 32'h01, 0, 1, 32'h1, 3'd0);
    expect_reg("R7 raw ring wins", 4'h8, 32'h03);

    // R10 both ports ring
    cur_tag = "R10";
    cyc(1, 4'h8, 32'h3F, 0, 0, 0, 0);
    cyc(1, 4'h0, 32'h1, 3'd5, 1, 32'h1, 3'd3);
    expect_reg("R10 raw both", 4'h8, 32'h28);
    expect_reg("R10 pending enabled only", 4'hC, 32'h21);

    // R3 enable write racing a ring
    cur_tag = "R3";
    cyc(1, 4'h4, 32'h3F, 0, 1, 32'h1, 3'd4);
    expect_reg("R3 same-cycle enable not used", 4'hC, 32'h21);
    expect_reg("R3 raw still records", 4'h8, 32'h38);

    // R11 misaligned access
    cur_tag = "R11";
    cyc(1, 4'h5, 32'h0, 0, 0, 0, 0);
    expect_reg("R11 misaligned write ignored", 4'h4, 32'h3F);
    expect_reg("R11 misaligned read zero", 4'h9, 32'h0);

    repeat (2) @(posedge clk);
    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule